// File: doc/BRIEF.md
# Saturating Usage Log Updater

This block keeps a small usage record, meant to be copied to and from a serial non-volatile memory by other logic. The record sits in an eight-byte register image. It holds a one-byte checksum, a length field, four 8-bit error tallies and a 16-bit power-on-hours value. Error events arrive as increment requests that name a tally and an amount. These collect in saturating pending counters. A one-per-second tick feeds an hours counter that keeps the seconds left over.

An update request first checks whether there is anything to log. If there is, the block verifies the stored checksum and refuses the update when it does not match. On a match it folds the pending tallies and the whole elapsed hours into the image, seals the image with a fresh checksum, and reports how many leading bytes must be rewritten. That count runs up to the highest byte whose value actually changed. The image is loaded and read back through a simple byte port while the block is idle.

Top module: `usage_log_updater`

## Requirements
- R1: An increment request adds `inc_amt` to the pending counter selected by `inc_idx`. A pending counter never exceeds 255: sums above 255 become 255.
- R2: When every pending counter is zero and less than one whole hour is held, an update request produces `upd_done` one cycle later with result 0 (nothing to log) and length 0, and leaves the image unchanged.
- R3: The checksum is computed as follows. Take the length byte at offset 1 and clamp it to 8; call it L. Add bytes 0..L-1 modulo 256, subtract byte 0, and invert the bits. If this does not equal byte 0, the update finishes two cycles after the request with result 3 (rejected) and length 0. The image, the pending counters and the held hours are all left unchanged.
- R4: On an accepted update, each error byte at offsets 2..5 (tally 0..3) that has a non-zero pending count becomes stored+pending, capped at 255. All pending counters then return to zero.
- R5: Every 3600 ticks of `sec_tick` make one whole hour, and the seconds beyond whole hours are kept. An accepted update adds the held hours to the 16-bit little-endian value at offsets 6 (low) and 7 (high), capped at 0xFFFF, and clears only the whole hours.
- R6: An accepted update finishes three cycles after the request. If at least one byte changed, the result is 1 (written) and the length is the highest changed offset plus one. If no byte changed, the result is 2 (unchanged) and the length is 0.
- R7: After a written update, byte 0 holds the checksum of R3 computed over the new image, including the clamp of the length field.
- R8: Increments that arrive while `upd_busy` is high are not lost. They reach the pending counters once the update ends, with the same saturation.
- R9: `img_rd_data` shows the image byte at `img_addr` one cycle later. Writes on the byte port take effect only while `upd_busy` is low and are ignored while it is high.
- R10: After reset, `upd_busy`, `upd_done`, `upd_result` and `upd_len` are 0, every image byte is 0 and every pending counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_valid | input | 1 | Increment request strobe |
| inc_idx | input | 2 | Tally selected by the increment |
| inc_amt | input | 8 | Amount to add |
| sec_tick | input | 1 | One-second tick |
| upd_req | input | 1 | Update request strobe |
| img_wr_en | input | 1 | Byte port write enable |
| img_addr | input | 3 | Byte port address |
| img_wr_data | input | 8 | Byte port write data |
| img_rd_data | output | 8 | Byte port read data, one cycle after the address |
| upd_busy | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle pulse when an update ends |
| upd_result | output | 2 | 0 nothing, 1 written, 2 unchanged, 3 rejected |
| upd_len | output | 4 | Number of leading bytes to rewrite |

## Verification
Two pairs of events can land on the same clock. The first is an increment arriving in the very cycle that folds and clears the pending counters. The second is a seconds tick completing an hour while the held hours are being consumed. The bench drives increments and byte-port writes in the cycles right after an update request, and sweeps ticks across several hour boundaries with updates in between. A behavioural per-cycle model of the pending, shadow and hour state then judges whether each count landed exactly once and whether the leftover seconds carried over.

// File: rtl/ulog_pkg.sv
package ulog_pkg;
  // record layout; the checksum, length and hours positions are decoded by the sealer
  localparam int IMG_BYTES  = 8;
  localparam int NUM_ERR    = 4;
  localparam int CNT_W      = 8;
  localparam int HRS_W      = 16;
  localparam int OFF_CSUM   = 0;
  localparam int OFF_LEN    = 1;
  localparam int OFF_ERR    = 2;
  localparam int OFF_HRS_LO = 6;
  localparam int OFF_HRS_HI = 7;

  typedef enum logic [1:0] {
    RES_NONE      = 2'd0,
    RES_WRITTEN   = 2'd1,
    RES_UNCHANGED = 2'd2,
    RES_REJECTED  = 2'd3
  } ulog_res_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_SEAL  = 2'd2
  } ulog_st_e;
endpackage

// File: rtl/ulog_pending.sv
// Saturating pending tallies with a shadow set that collects requests during an update.
module ulog_pending #(
  parameter int NUM = 4,
  parameter int W   = 8,
  localparam int IW = $clog2(NUM)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inc_valid,
  input  logic [IW-1:0]         inc_idx,
  input  logic [W-1:0]          inc_amt,
  input  logic                  held,
  input  logic                  clear,
  output logic [NUM-1:0][W-1:0] pend
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  for (genvar g = 0; g < NUM; g++) begin : g_tally
    logic [W-1:0] shadow_q;
    logic [W-1:0] add_v;
    logic [W+1:0] merged;
    logic [W:0]   sh_sum;

    assign add_v  = (inc_valid && inc_idx == IW'(g)) ? inc_amt : '0;
    assign merged = {2'b00, pend[g]} + {2'b00, shadow_q} + {2'b00, add_v};
    assign sh_sum = {1'b0, shadow_q} + {1'b0, add_v};

    always_ff @(posedge clk) begin
      if (rst) begin
        pend[g]  <= '0;
        shadow_q <= '0;
      end else if (!held) begin
        pend[g]  <= (merged > {2'b00, MAXV}) ? MAXV : merged[W-1:0];
        shadow_q <= '0;
      end else begin
        shadow_q <= sh_sum[W] ? MAXV : sh_sum[W-1:0];
        if (clear) pend[g] <= '0;
      end
    end
  end
endmodule

// File: rtl/ulog_hours.sv
// Seconds counter wrapping at one hour plus a saturating count of whole hours.
module ulog_hours #(
  parameter int SPH = 3600,
  parameter int HW  = 16,
  localparam int SW = $clog2(SPH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          take,
  output logic [HW-1:0] hours
);
  logic [SW-1:0] sec_q;
  logic          carry;

  assign carry = tick && (sec_q == SW'(SPH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      hours <= '0;
    end else begin
      sec_q <= carry ? '0 : sec_q + SW'(tick);
      if (take)
        hours <= HW'(carry);
      else if (carry && hours != {HW{1'b1}})
        hours <= hours + 1'b1;
    end
  end
endmodule

// File: rtl/ulog_csum.sv
// Complement-of-sum over a clamped prefix, the checksum byte's own share removed.
module ulog_csum #(
  parameter int N       = 8,
  parameter int LEN_OFF = 1,
  parameter int CS_OFF  = 0
) (
  input  logic [N-1:0][7:0] img,
  output logic [7:0]        csum
);
  logic [8:0] eff;
  logic [7:0] acc;

  always_comb begin
    eff = (img[LEN_OFF] > 8'(N)) ? 9'(N) : {1'b0, img[LEN_OFF]};
    acc = 8'd0;
    for (int i = 0; i < N; i++) begin
      if (9'(i) < eff) acc = acc + img[i];
    end
    acc  = acc - img[CS_OFF];
    csum = ~acc;
  end
endmodule

// File: rtl/usage_log_updater.sv
module usage_log_updater
  import ulog_pkg::*;
#(
  parameter int SEC_PER_HOUR = 3600,
  localparam int AW = $clog2(IMG_BYTES),
  localparam int LW = $clog2(IMG_BYTES + 1),
  localparam int IW = $clog2(NUM_ERR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_valid,
  input  logic [IW-1:0] inc_idx,
  input  logic [7:0]    inc_amt,
  input  logic          sec_tick,
  input  logic          upd_req,
  input  logic          img_wr_en,
  input  logic [AW-1:0] img_addr,
  input  logic [7:0]    img_wr_data,
  output logic [7:0]    img_rd_data,
  output logic          upd_busy,
  output logic          upd_done,
  output logic [1:0]    upd_result,
  output logic [LW-1:0] upd_len
);
  logic [IMG_BYTES-1:0][7:0]   img_q;
  logic [IMG_BYTES-1:0][7:0]   img_fold;
  logic [NUM_ERR-1:0][CNT_W-1:0] pend_w;
  logic [HRS_W-1:0]            hours_w;
  logic [7:0]                  csum_now;
  logic [LW-1:0]               chg_len;
  logic [LW-1:0]               chg_len_q;
  ulog_st_e                    state_q;
  ulog_res_e                   res_q;
  logic                        need_work;
  logic                        csum_ok;
  logic                        fold_go;

  assign upd_busy   = (state_q != ST_IDLE);
  assign upd_result = res_q;
  assign need_work  = (|pend_w) || (|hours_w);
  assign csum_ok    = (csum_now == img_q[OFF_CSUM]);
  assign fold_go    = (state_q == ST_CHECK) && csum_ok;

  ulog_pending #(.NUM(NUM_ERR), .W(CNT_W)) u_pending (
    .clk(clk), .rst(rst), .inc_valid(inc_valid), .inc_idx(inc_idx),
    .inc_amt(inc_amt), .held(upd_busy), .clear(fold_go), .pend(pend_w)
  );

  ulog_hours #(.SPH(SEC_PER_HOUR), .HW(HRS_W)) u_hours (
    .clk(clk), .rst(rst), .tick(sec_tick), .take(fold_go), .hours(hours_w)
  );

  ulog_csum #(.N(IMG_BYTES), .LEN_OFF(OFF_LEN), .CS_OFF(OFF_CSUM)) u_csum (
    .img(img_q), .csum(csum_now)
  );

  // fold pending tallies and whole hours into a candidate image, tracking the last changed byte
  logic [8:0]       esum;
  logic [7:0]       enew;
  logic [HRS_W-1:0] hstored;
  logic [HRS_W:0]   hsum;
  logic [HRS_W-1:0] hnew;

  always_comb begin
    img_fold = img_q;
    chg_len  = '0;
    esum     = '0;
    enew     = '0;
    for (int e = 0; e < NUM_ERR; e++) begin
      esum = {1'b0, img_q[OFF_ERR+e]} + {1'b0, pend_w[e]};
      enew = esum[8] ? 8'hFF : esum[7:0];
      if (pend_w[e] != '0 && enew != img_q[OFF_ERR+e]) begin
        img_fold[OFF_ERR+e] = enew;
        chg_len             = LW'(OFF_ERR + e + 1);
      end
    end
    hstored = {img_q[OFF_HRS_HI], img_q[OFF_HRS_LO]};
    hsum    = {1'b0, hstored} + {1'b0, hours_w};
    hnew    = hsum[HRS_W] ? {HRS_W{1'b1}} : hsum[HRS_W-1:0];
    if (hours_w != '0) begin
      if (hnew[7:0] != img_q[OFF_HRS_LO]) begin
        img_fold[OFF_HRS_LO] = hnew[7:0];
        chg_len              = LW'(OFF_HRS_LO + 1);
      end
      if (hnew[15:8] != img_q[OFF_HRS_HI]) begin
        img_fold[OFF_HRS_HI] = hnew[15:8];
        chg_len              = LW'(OFF_HRS_HI + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      res_q     <= RES_NONE;
      upd_done  <= 1'b0;
      upd_len   <= '0;
      chg_len_q <= '0;
      img_q     <= '0;
    end else begin
      upd_done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (upd_req) begin
            if (need_work) begin
              state_q <= ST_CHECK;
            end else begin
              upd_done <= 1'b1;
              res_q    <= RES_NONE;
              upd_len  <= '0;
            end
          end
          if (img_wr_en) img_q[img_addr] <= img_wr_data;
        end
        ST_CHECK: begin
          if (!csum_ok) begin
            upd_done <= 1'b1;
            res_q    <= RES_REJECTED;
            upd_len  <= '0;
            state_q  <= ST_IDLE;
          end else begin
            img_q     <= img_fold;
            chg_len_q <= chg_len;
            state_q   <= ST_SEAL;
          end
        end
        ST_SEAL: begin
          if (chg_len_q != '0) begin
            img_q[OFF_CSUM] <= csum_now;
            res_q           <= RES_WRITTEN;
            upd_len         <= chg_len_q;
          end else begin
            res_q   <= RES_UNCHANGED;
            upd_len <= '0;
          end
          upd_done <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) img_rd_data <= '0;
    else     img_rd_data <= img_q[img_addr];
  end
endmodule

// File: rtl/ulog_checker.sv
module ulog_checker #(
  parameter int N   = 8,
  parameter int NUM = 4,
  parameter int LW  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             upd_done,
  input logic             upd_busy,
  input logic [1:0]       upd_result,
  input logic [LW-1:0]    upd_len,
  input logic [7:0]       csum_calc,
  input logic [7:0]       csum_stored,
  input logic [NUM*8-1:0] pend,
  input logic [15:0]      hours,
  input logic             take
);
  a_r6_done_leaves_idle: assert property (@(posedge clk) disable iff (rst)
    upd_done |-> !upd_busy);

  a_r7_sealed_matches: assert property (@(posedge clk) disable iff (rst)
    (upd_done && upd_result == 2'd1) |-> (csum_stored == csum_calc));

  a_r6_len_in_range: assert property (@(posedge clk) disable iff (rst)
    (upd_done && upd_result == 2'd1) |-> (upd_len != '0 && upd_len <= LW'(N)));

  a_r2_len_zero_otherwise: assert property (@(posedge clk) disable iff (rst)
    (upd_done && upd_result != 2'd1) |-> (upd_len == '0));

  a_r3_reject_keeps_pending: assert property (@(posedge clk) disable iff (rst)
    (upd_done && upd_result == 2'd3) |-> (pend == $past(pend)));

  a_r8_pending_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    (upd_busy && !take) |=> $stable(pend));

  a_r5_hours_saturate: assert property (@(posedge clk) disable iff (rst)
    (hours == 16'hFFFF && !take) |=> (hours == 16'hFFFF));
endmodule

bind usage_log_updater ulog_checker #(
  .N(ulog_pkg::IMG_BYTES), .NUM(ulog_pkg::NUM_ERR), .LW(LW)
) u_ulog_checker (
  .clk(clk), .rst(rst), .upd_done(upd_done), .upd_busy(upd_busy),
  .upd_result(upd_result), .upd_len(upd_len), .csum_calc(csum_now),
  .csum_stored(img_q[0]), .pend(pend_w), .hours(hours_w), .take(fold_go)
);

// File: tb/test_usage_log_updater.sv
module test_usage_log_updater;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inc_valid = 1'b0;
  logic [1:0] inc_idx = '0;
  logic [7:0] inc_amt = '0;
  logic       sec_tick = 1'b0;
  logic       upd_req = 1'b0;
  logic       img_wr_en = 1'b0;
  logic [2:0] img_addr = '0;
  logic [7:0] img_wr_data = '0;
  logic [7:0] img_rd_data;
  logic       upd_busy, upd_done;
  logic [1:0] upd_result;
  logic [3:0] upd_len;

  always #2.5 clk = ~clk;

  usage_log_updater i_usage_log_updater (
    .clk(clk), .rst(rst), .inc_valid(inc_valid), .inc_idx(inc_idx),
    .inc_amt(inc_amt), .sec_tick(sec_tick), .upd_req(upd_req),
    .img_wr_en(img_wr_en), .img_addr(img_addr), .img_wr_data(img_wr_data),
    .img_rd_data(img_rd_data), .upd_busy(upd_busy), .upd_done(upd_done),
    .upd_result(upd_result), .upd_len(upd_len)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int f_csum(input int b[8]);
    int eff = (b[1] > 8) ? 8 : b[1];
    int s = 0;
    for (int i = 0; i < eff; i++) s += b[i];
    s -= b[0];
    return (~s) & 255;
  endfunction

  // behavioural reference model, advanced on every rising edge
  int m_img[8];
  int m_pend[4];
  int m_sh[4];
  int m_sec, m_hrs, m_st, m_hw, m_res, m_len, m_rd;
  bit m_done, m_busy;

  always @(posedge clk) begin
    int oldst, nv, oldh, nh, a, carry;
    bit fold, anyp;
    if (rst) begin
      for (int i = 0; i < 8; i++) m_img[i] = 0;
      for (int e = 0; e < 4; e++) begin m_pend[e] = 0; m_sh[e] = 0; end
      m_sec = 0; m_hrs = 0; m_st = 0; m_hw = 0; m_res = 0; m_len = 0; m_rd = 0;
      m_done = 0;
    end else begin
      m_rd = m_img[img_addr];
      oldst = m_st; m_done = 0; fold = 0;
      anyp = 0;
      for (int e = 0; e < 4; e++) if (m_pend[e] != 0) anyp = 1;
      case (oldst)
        0: if (upd_req) begin
             if (anyp || m_hrs > 0) m_st = 1;
             else begin m_done = 1; m_res = 0; m_len = 0; end
           end
        1: if (f_csum(m_img) != m_img[0]) begin
             m_done = 1; m_res = 3; m_len = 0; m_st = 0;
           end else begin
             fold = 1; m_hw = 0;
             for (int e = 0; e < 4; e++) if (m_pend[e] != 0) begin
               nv = m_img[2+e] + m_pend[e]; if (nv > 255) nv = 255;
               if (nv != m_img[2+e]) begin m_img[2+e] = nv; m_hw = 3 + e; end
             end
             if (m_hrs > 0) begin
               oldh = m_img[6] + 256 * m_img[7];
               nh = oldh + m_hrs; if (nh > 65535) nh = 65535;
               if ((nh & 255) != m_img[6]) begin m_img[6] = nh & 255; m_hw = 7; end
               if ((nh >> 8) != m_img[7]) begin m_img[7] = nh >> 8; m_hw = 8; end
             end
             m_st = 2;
           end
        default: begin
             if (m_hw != 0) begin m_img[0] = f_csum(m_img); m_res = 1; m_len = m_hw; end
             else begin m_res = 2; m_len = 0; end
             m_done = 1; m_st = 0;
           end
      endcase
      if (oldst == 0 && img_wr_en) m_img[img_addr] = img_wr_data;
      for (int e = 0; e < 4; e++) begin
        a = (inc_valid && inc_idx == e) ? inc_amt : 0;
        if (oldst == 0) begin
          m_pend[e] = m_pend[e] + m_sh[e] + a; if (m_pend[e] > 255) m_pend[e] = 255;
          m_sh[e] = 0;
        end else begin
          m_sh[e] = m_sh[e] + a; if (m_sh[e] > 255) m_sh[e] = 255;
          if (fold) m_pend[e] = 0;
        end
      end
      carry = (sec_tick && m_sec == 3599) ? 1 : 0;
      m_sec = carry ? 0 : m_sec + (sec_tick ? 1 : 0);
      if (fold) m_hrs = carry;
      else begin m_hrs = m_hrs + carry; if (m_hrs > 65535) m_hrs = 65535; end
    end
    m_busy = (m_st != 0);
  end

  // per-cycle comparison against the model, away from the active edge
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(upd_busy == m_busy, "R8 busy vs model", upd_busy, m_busy);
      check(upd_done == m_done, "R6 done timing vs model", upd_done, m_done);
      if (m_done) begin
        check(upd_result == m_res, "R3 R6 result vs model", upd_result, m_res);
        check(upd_len == m_len, "R6 length vs model", upd_len, m_len);
      end
      check(img_rd_data == m_rd, "R9 read data vs model", img_rd_data, m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); img_wr_en = 1; img_addr = 3'(a); img_wr_data = 8'(d);
    @(negedge clk); img_wr_en = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); img_addr = 3'(a);
    @(negedge clk); d = img_rd_data;
  endtask

  task automatic inc(input int idx, input int amt);
    @(negedge clk); inc_valid = 1; inc_idx = 2'(idx); inc_amt = 8'(amt);
    @(negedge clk); inc_valid = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); sec_tick = 1;
    repeat (n) @(negedge clk);
    sec_tick = 0;
  endtask

  task automatic wait_done(output int r, output int l);
    r = -1; l = -1;
    for (int k = 0; k < 8; k++) begin
      if (upd_done) begin r = upd_result; l = upd_len; break; end
      @(negedge clk);
    end
  endtask

  task automatic do_update(output int r, output int l);
    @(negedge clk); upd_req = 1;
    @(negedge clk); upd_req = 0;
    wait_done(r, l);
  endtask

  task automatic read_all(output int b[8]);
    for (int i = 0; i < 8; i++) begin int d; rd(i, d); b[i] = d; end
  endtask

  task automatic reseal();
    int b[8];
    read_all(b);
    wr(0, f_csum(b));
  endtask

  initial begin
    int r, l, d;
    int b[8];
    repeat (4) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    // R10 reset state
    check(upd_busy == 0, "R10 busy after reset", upd_busy, 0);
    check(upd_done == 0, "R10 done after reset", upd_done, 0);
    check(upd_result == 0 && upd_len == 0, "R10 result and length after reset", upd_len, 0);
    read_all(b);
    for (int i = 0; i < 8; i++) check(b[i] == 0, "R10 image byte zero", b[i], 0);

    // load a valid record: length 8, tallies 10 20 30 40, hours 0x0102
    wr(1, 8); wr(2, 10); wr(3, 20); wr(4, 30); wr(5, 40); wr(6, 2); wr(7, 1);
    reseal();
    do_update(r, l);
    check(r == 0, "R2 nothing to log result", r, 0);
    check(l == 0, "R2 nothing to log length", l, 0);
    rd(2, d); check(d == 10, "R2 image untouched", d, 10);

    // R1 saturation of pending, R4 fold
    inc(1, 5); inc(1, 255); inc(0, 3);
    do_update(r, l);
    check(r == 1, "R4 written result", r, 1);
    check(l == 4, "R6 high-water length", l, 4);
    rd(2, d); check(d == 13, "R4 tally0 folded", d, 13);
    rd(3, d); check(d == 255, "R1 pending saturated, R4 stored capped", d, 255);
    read_all(b); check(b[0] == f_csum(b), "R7 resealed checksum", b[0], f_csum(b));
    do_update(r, l);
    check(r == 0, "R4 pending cleared after fold", r, 0);

    // R3 bad checksum rejected, pending kept
    wr(4, 99); inc(2, 1);
    do_update(r, l);
    check(r == 3, "R3 reject result", r, 3);
    check(l == 0, "R3 reject length", l, 0);
    rd(4, d); check(d == 99, "R3 image untouched on reject", d, 99);
    reseal();
    do_update(r, l);
    check(r == 1 && l == 5, "R3 pending survives reject", l, 5);
    rd(4, d); check(d == 100, "R3 tally2 after retry", d, 100);

    // R5 hours with remainder kept
    ticks(7300);
    do_update(r, l);
    check(r == 1 && l == 7, "R5 hours low byte changed", l, 7);
    rd(6, d); check(d == 4, "R5 two hours added", d, 4);
    ticks(3500);
    do_update(r, l);
    rd(6, d); check(d == 5, "R5 remainder carried into next hour", d, 5);

    // R5 saturation at 0xFFFF
    wr(6, 8'hFE); wr(7, 8'hFF); reseal();
    ticks(7200);
    do_update(r, l);
    check(l == 7, "R6 only low hours byte changed", l, 7);
    rd(6, d); check(d == 255, "R5 hours low saturated", d, 255);
    rd(7, d); check(d == 255, "R5 hours high saturated", d, 255);

    // R6 unchanged: tally1 already at 255
    inc(1, 7);
    do_update(r, l);
    check(r == 2, "R6 unchanged result", r, 2);
    check(l == 0, "R6 unchanged length", l, 0);

    // R8 increment and R9 write during busy
    inc(3, 1);
    @(negedge clk); upd_req = 1;
    @(negedge clk); upd_req = 0;
    inc_valid = 1; inc_idx = 2'd0; inc_amt = 8'd4;
    img_wr_en = 1; img_addr = 3'd5; img_wr_data = 8'd0;
    @(negedge clk); inc_valid = 0; img_wr_en = 0;
    wait_done(r, l);
    check(r == 1 && l == 6, "R8 update with increment in flight", l, 6);
    rd(5, d); check(d == 41, "R9 write during busy ignored", d, 41);
    do_update(r, l);
    check(r == 1 && l == 3, "R8 held increment applied later", l, 3);
    rd(2, d); check(d == 17, "R8 held amount folded", d, 17);

    // R7 short length field, then a length above the image size
    wr(1, 3); reseal();
    inc(2, 1);
    do_update(r, l);
    check(r == 1 && l == 5, "R7 short length accepted", l, 5);
    read_all(b); check(b[0] == f_csum(b), "R7 seal over short prefix", b[0], f_csum(b));
    wr(1, 200); reseal();
    inc(3, 2);
    do_update(r, l);
    check(r == 1 && l == 6, "R7 clamped length accepted", l, 6);
    read_all(b); check(b[0] == f_csum(b), "R7 seal with clamp", b[0], f_csum(b));

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule